// File: doc/BRIEF.md
# Three-Phase Gate Sequencer with Dead Time

This block turns a controller's per-phase high-side and low-side commands into gate commands for the six switches of a three-phase bridge. Each phase channel decodes its two command bits, refuses to drive both switches of a leg at once, and holds any turn-on back until the opposite switch of the same leg has been off for a programmable number of clock cycles. Turning a switch off is never delayed.

The dead time is set by a small digital code instead of an analog trim. Code 0 selects the shortest gap, and each step of the code adds a fixed number of cycles. A global enable input forces every gate command low and raises a flag that tells the output stage to release the gates to high impedance. The controller drives the commands, the code and the enable, and the gate outputs go to the level shifters of the bridge.

Top module: `bridge_gate_sequencer`

## Requirements
- R1: A phase with high command 1 and low command 0 drives its high gate to 1 once the dead time allows, and its low gate is 0 in the cycle the command is applied.
- R2: A phase with high command 0 and low command 1 drives its low gate to 1 once the dead time allows, and its high gate is 0 in the cycle the command is applied.
- R3: A phase with both commands 0 has both gates at 0 in the same cycle.
- R4: A phase with both commands 1 has both gates at 0 in the same cycle. Neither command wins.
- R5: The high gate and the low gate of one phase are never 1 in the same cycle, whatever the code, the commands or the enable.
- R6: The dead time is D = MIN_DT_CYCLES + code * STEP_CYCLES clock cycles. If the opposite gate is first 0 in cycle t and the request is present by cycle t+D-1, the gate becomes 1 in cycle t+D. A request made later turns the gate on one cycle after the request.
- R7: Code 0 gives the minimum dead time of MIN_DT_CYCLES cycles (6 cycles with the default parameters).
- R8: Removing a command turns its gate off in the same cycle.
- R9: While the enable is 0, every gate output is 0 and hiZ is 1 in the same cycle. While the enable is 1, hiZ is 0.
- R10: During reset every gate output is 0. After reset is released, both gates count as having gone low in the release cycle, so the first turn-on also waits the full dead time.
- R11: The dead-time count goes on while the enable is 0. If the enable returns after the opposite gate has been 0 for at least D cycles, a gate whose command is held turns on one cycle after the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global gate enable; 0 forces all gates off |
| hiCmd | input | NUM_PH | High-side command, one bit per phase |
| loCmd | input | NUM_PH | Low-side command, one bit per phase |
| dtSetting | input | DT_W | Dead-time code |
| gateHi | output | NUM_PH | High-side gate command, one bit per phase |
| gateLo | output | NUM_PH | Low-side gate command, one bit per phase |
| hiZ | output | 1 | Asserted while the gates are released |

## Verification
Several properties are checked in every cycle. No leg ever drives both gates. A rising gate always follows at least the programmed dead time on its partner. Conflicting or idle commands and a withdrawn command give a low gate at once. A deasserted enable means hiZ is set and every output is low. Only the bench scenarios can show the exact cycle of each turn-on: the minimum and maximum codes, a late request after a long off period, the wait after reset, and the turn-on one cycle after the enable returns.

// File: rtl/bridge_gate_pkg.sv
package bridge_gate_pkg;

  // Per-phase strobes from the command control to the timing datapath.
  typedef struct packed {
    logic allowHi;  // high side may be on this cycle
    logic allowLo;  // low side may be on this cycle
    logic armHi;    // high side may turn on at the next edge
    logic armLo;    // low side may turn on at the next edge
  } phaseStrobe_t;

endpackage

// File: rtl/gate_cmd_ctrl.sv
module gate_cmd_ctrl
  import bridge_gate_pkg::*;
#(
  parameter int NUM_PH = 3
) (
  input  logic                      enable,
  input  logic [NUM_PH-1:0]         hiCmd,
  input  logic [NUM_PH-1:0]         loCmd,
  input  logic [NUM_PH-1:0]         hiReady,
  input  logic [NUM_PH-1:0]         loReady,
  output phaseStrobe_t [NUM_PH-1:0] strobe,
  output logic                      hiZ
);

  assign hiZ = ~enable;

  for (genvar i = 0; i < NUM_PH; i++) begin : g_phase
    logic reqHi;
    logic reqLo;

    // Conflicting commands request neither side.
    assign reqHi = hiCmd[i] & ~loCmd[i];
    assign reqLo = loCmd[i] & ~hiCmd[i];

    always_comb begin
      strobe[i].allowHi = enable & reqHi;
      strobe[i].allowLo = enable & reqLo;
      strobe[i].armHi   = enable & reqHi & hiReady[i];
      strobe[i].armLo   = enable & reqLo & loReady[i];
    end
  end

endmodule

// File: rtl/gate_timing_path.sv
module gate_timing_path
  import bridge_gate_pkg::*;
#(
  parameter int NUM_PH        = 3,
  parameter int DT_W          = 4,
  parameter int MIN_DT_CYCLES = 6,
  parameter int STEP_CYCLES   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DT_W-1:0]           dtSetting,
  input  phaseStrobe_t [NUM_PH-1:0] strobe,
  output logic [NUM_PH-1:0]         gateHi,
  output logic [NUM_PH-1:0]         gateLo,
  output logic [NUM_PH-1:0]         hiReady,
  output logic [NUM_PH-1:0]         loReady
);

  localparam int MAX_DT = MIN_DT_CYCLES + ((1 << DT_W) - 1) * STEP_CYCLES;
  localparam int CNT_W  = $clog2(MAX_DT + 1);
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_DT_CYCLES);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP_CYCLES);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_DT);
  localparam logic [CNT_W:0]   ONE    = (CNT_W+1)'(1);

  logic [CNT_W-1:0] dtCycles;
  assign dtCycles = MIN_C + CNT_W'(dtSetting) * STEP_C;

  for (genvar i = 0; i < NUM_PH; i++) begin : g_phase
    logic             regHi;
    logic             regLo;
    logic [CNT_W-1:0] hiLowCnt;  // cycles the high gate has been low
    logic [CNT_W-1:0] loLowCnt;  // cycles the low gate has been low

    // Turn-off is combinational: a withdrawn allow drops the gate at once.
    assign gateHi[i] = regHi & strobe[i].allowHi;
    assign gateLo[i] = regLo & strobe[i].allowLo;

    // Counting the current cycle, has the opposite gate been low long enough?
    assign hiReady[i] = ({1'b0, loLowCnt} + ONE) >= {1'b0, dtCycles};
    assign loReady[i] = ({1'b0, hiLowCnt} + ONE) >= {1'b0, dtCycles};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regHi    <= 1'b0;
        regLo    <= 1'b0;
        hiLowCnt <= '0;
        loLowCnt <= '0;
      end else begin
        regHi <= strobe[i].allowHi & (regHi | strobe[i].armHi);
        regLo <= strobe[i].allowLo & (regLo | strobe[i].armLo);
        if (gateHi[i])             hiLowCnt <= '0;
        else if (hiLowCnt != MAX_C) hiLowCnt <= hiLowCnt + 1'b1;
        if (gateLo[i])             loLowCnt <= '0;
        else if (loLowCnt != MAX_C) loLowCnt <= loLowCnt + 1'b1;
      end
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[i] && gateLo[i])); // R5

    AST_HI_DEAD_TIME: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateHi[i]) |-> (loLowCnt >= $past(dtCycles))); // R6

    AST_LO_DEAD_TIME: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateLo[i]) |-> (hiLowCnt >= $past(dtCycles))); // R6
  end

endmodule

// File: rtl/bridge_gate_sequencer.sv
module bridge_gate_sequencer
  import bridge_gate_pkg::*;
#(
  parameter int NUM_PH        = 3,
  parameter int DT_W          = 4,
  parameter int MIN_DT_CYCLES = 6,
  parameter int STEP_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [NUM_PH-1:0] hiCmd,
  input  logic [NUM_PH-1:0] loCmd,
  input  logic [DT_W-1:0]   dtSetting,
  output logic [NUM_PH-1:0] gateHi,
  output logic [NUM_PH-1:0] gateLo,
  output logic              hiZ
);

  phaseStrobe_t [NUM_PH-1:0] strobe;
  logic [NUM_PH-1:0]         hiReady;
  logic [NUM_PH-1:0]         loReady;

  gate_cmd_ctrl #(.NUM_PH(NUM_PH)) u_ctrl (
    .enable  (enable),
    .hiCmd   (hiCmd),
    .loCmd   (loCmd),
    .hiReady (hiReady),
    .loReady (loReady),
    .strobe  (strobe),
    .hiZ     (hiZ)
  );

  gate_timing_path #(
    .NUM_PH        (NUM_PH),
    .DT_W          (DT_W),
    .MIN_DT_CYCLES (MIN_DT_CYCLES),
    .STEP_CYCLES   (STEP_CYCLES)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .dtSetting (dtSetting),
    .strobe    (strobe),
    .gateHi    (gateHi),
    .gateLo    (gateLo),
    .hiReady   (hiReady),
    .loReady   (loReady)
  );

  AST_RELEASED_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    hiZ |-> (gateHi == '0 && gateLo == '0)); // R9

  AST_ENABLE_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    enable != hiZ); // R9

  AST_CONFLICT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (hiCmd & loCmd & (gateHi | gateLo)) == '0); // R4

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (~hiCmd & ~loCmd & (gateHi | gateLo)) == '0); // R3

  AST_PROMPT_TURN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((gateHi & ~hiCmd) | (gateLo & ~loCmd)) == '0); // R8

endmodule

// File: tb/bridge_gate_sequencer_bench.sv
module bridge_gate_sequencer_bench;

  localparam int NUM_PH = 3;
  localparam int DT_W   = 4;
  localparam int MIN_DT = 6;
  localparam int STEP   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b1;
  logic [NUM_PH-1:0] hiCmd = '0;
  logic [NUM_PH-1:0] loCmd = '0;
  logic [DT_W-1:0]   dtSetting = '0;
  logic [NUM_PH-1:0] gateHi;
  logic [NUM_PH-1:0] gateLo;
  logic              hiZ;

  bridge_gate_sequencer #(
    .NUM_PH(NUM_PH), .DT_W(DT_W), .MIN_DT_CYCLES(MIN_DT), .STEP_CYCLES(STEP)
  ) u_bridge_gate_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .hiCmd(hiCmd), .loCmd(loCmd),
    .dtSetting(dtSetting), .gateHi(gateHi), .gateLo(gateLo), .hiZ(hiZ)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int    cyc;
    int    ph;
    bit    hi;
    bit    lo;
    bit    hz;
    string tag;
  } expItem_t;

  expItem_t sbq[$];
  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  running = 1'b0;
  int  dtNow = MIN_DT;
  bit  expHi[NUM_PH];
  bit  expLo[NUM_PH];
  int  lowHi[NUM_PH];
  int  lowLo[NUM_PH];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic expectAt(int cy, int p, bit h, bit l, bit z, string tag);
    expItem_t it;
    it.cyc = cy; it.ph = p; it.hi = h; it.lo = l; it.hz = z; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: pops scoreboard items whose cycle has come, plus a leg check.
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if ((gateHi & gateLo) != '0) begin
        errors++;
        $display("FAIL R5 cycle %0d: hi=%b lo=%b expected no overlap", cyc, gateHi, gateLo);
      end
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        expItem_t it;
        it = sbq.pop_front();
        checks++;
        if (it.cyc != cyc || gateHi[it.ph] !== it.hi || gateLo[it.ph] !== it.lo || hiZ !== it.hz) begin
          errors++;
          $display("FAIL %s cycle %0d (exp cycle %0d) phase %0d: got hi=%b lo=%b hz=%b expected hi=%b lo=%b hz=%b",
                   it.tag, cyc, it.cyc, it.ph, gateHi[it.ph], gateLo[it.ph], hiZ, it.hi, it.lo, it.hz);
        end
      end
    end
  end

  task automatic drivePhase(int p, bit h, bit l, string tag);
    int c;
    int rise;
    bit rh;
    bit rl;
    @(posedge clk); #2;
    hiCmd[p] = h;
    loCmd[p] = l;
    c = cyc;
    rh = h && !l;
    rl = l && !h;
    if (!rh && expHi[p]) begin expHi[p] = 1'b0; lowHi[p] = c; end
    if (!rl && expLo[p]) begin expLo[p] = 1'b0; lowLo[p] = c; end
    rise = -1;
    if (enable && rh && !expHi[p]) rise = maxOf(c + 1, lowLo[p] + dtNow);
    if (enable && rl && !expLo[p]) rise = maxOf(c + 1, lowHi[p] + dtNow);
    expectAt(c, p, expHi[p], expLo[p], !enable, tag);
    if (rise >= 0) begin
      if (rise - 1 > c) expectAt(rise - 1, p, 1'b0, 1'b0, 1'b0, tag);
      if (rh) expHi[p] = 1'b1; else expLo[p] = 1'b1;
      expectAt(rise, p, expHi[p], expLo[p], 1'b0, tag);
      while (cyc <= rise) @(posedge clk);
    end else begin
      repeat (2) @(posedge clk);
    end
  endtask

  task automatic setEnable(bit e, string tag);
    int c;
    int last;
    @(posedge clk); #2;
    enable = e;
    c = cyc;
    last = c;
    for (int p = 0; p < NUM_PH; p++) begin
      if (!e) begin
        if (expHi[p]) begin expHi[p] = 1'b0; lowHi[p] = c; end
        if (expLo[p]) begin expLo[p] = 1'b0; lowLo[p] = c; end
        expectAt(c, p, 1'b0, 1'b0, 1'b1, tag);
      end else begin
        int rise;
        rise = -1;
        expectAt(c, p, 1'b0, 1'b0, 1'b0, tag);
        if (hiCmd[p] && !loCmd[p]) rise = maxOf(c + 1, lowLo[p] + dtNow);
        if (loCmd[p] && !hiCmd[p]) rise = maxOf(c + 1, lowHi[p] + dtNow);
        if (rise >= 0) begin
          if (hiCmd[p]) expHi[p] = 1'b1; else expLo[p] = 1'b1;
          expectAt(rise, p, expHi[p], expLo[p], 1'b0, tag);
          last = maxOf(last, rise);
        end
      end
    end
    sbq.sort() with (item.cyc);
    while (cyc <= last + 1) @(posedge clk);
  endtask

  task automatic setDt(int code);
    @(posedge clk); #2;
    dtSetting = DT_W'(code);
    dtNow = MIN_DT + code * STEP;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    for (int p = 0; p < NUM_PH; p++) begin
      expHi[p] = 1'b0; expLo[p] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R10 reset state
    if (gateHi !== '0 || gateLo !== '0 || hiZ !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: hi=%b lo=%b hz=%b expected 000 000 0", gateHi, gateLo, hiZ);
    end
    @(posedge clk); #2;
    rstN = 1'b1;
    for (int p = 0; p < NUM_PH; p++) begin
      lowHi[p] = cyc; lowLo[p] = cyc;
    end
    running = 1'b1;

    // Code 0: first turn-on right after reset waits the minimum dead time.
    drivePhase(0, 1, 0, "R10 R7 R1");
    drivePhase(0, 0, 1, "R2 R6 R7 R8");
    drivePhase(0, 1, 1, "R4");
    drivePhase(0, 1, 0, "R1 R6");
    drivePhase(0, 0, 0, "R3 R8");

    // Mid code, then a late request after a long off period.
    setDt(5);
    repeat (40) @(posedge clk);
    drivePhase(1, 1, 0, "R6 late request");
    drivePhase(1, 0, 1, "R6 R2 code5");
    drivePhase(1, 1, 1, "R4 R5");
    drivePhase(1, 1, 0, "R1 R6 code5");

    // Largest code.
    setDt(15);
    drivePhase(2, 0, 1, "R2 R10 code15");
    drivePhase(2, 1, 0, "R1 R6 code15");
    drivePhase(2, 0, 0, "R3");

    // Disable while gates are on, then re-enable.
    setDt(0);
    drivePhase(0, 0, 1, "R2 R7");
    setEnable(1'b0, "R9 disable");
    repeat (20) @(posedge clk);
    setEnable(1'b1, "R11 R9 re-enable");
    drivePhase(0, 1, 0, "R1 R6 after enable");
    drivePhase(1, 0, 0, "R3 R8");

    repeat (4) @(posedge clk);
    running = 1'b0;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    finishRun();
  end

endmodule